// File: doc/BRIEF.md
# Serial port register front-end with event interrupt

This block is the register-level face of a serial port. It sits on a simple 32-bit register bus with a 256-byte window. A single data register carries bytes both ways: a write hands one byte to a one-entry transmit holding stage, and a read takes the oldest byte out of an internal receive FIFO. Read-only flags report whether the transmit stage is occupied and whether the receive FIFO is empty. A raw-condition register shows both conditions together.

Two events, transmit and receive, each have a pending bit and an enable bit. A single level interrupt is raised whenever an enabled event is pending. The transmit event is latched when the holding stage drains and is cleared by writing a one to it. The receive event follows FIFO occupancy. It is re-evaluated on every pending or enable write and on every FIFO change, so a clear attempt while bytes are waiting has no effect.

Bytes arrive on a valid-only byte-stream input and leave on a valid/ready byte-stream output. Bit timing, baud generation, parity and stop bits belong to a neighbouring block.

Top module: `uart_regfront`

## Requirements
- R1: A write to offset 0x00 while the transmit stage is empty loads wdata[7:0] into it, and tx_valid is 1 with that byte on tx_data from the next cycle. A write while the stage is full is dropped. tx_data holds steady while tx_valid is high and tx_ready is low.
- R2: Offset 0x04 bit 0 (transmit-full) reads 1 while a byte is held, and tx_valid equals that flag. A cycle with tx_valid and tx_ready both high empties the stage at the next edge.
- R3: Bytes presented with rx_valid high are stored in arrival order in a FIFO of DEPTH (16) entries. A byte arriving while the FIFO already holds DEPTH bytes is dropped, and the FIFO contents stay unchanged.
- R4: A read of offset 0x00 returns the oldest received byte in bits 7:0, with the upper bits 0, and removes that byte at the end of the access. A read while the FIFO is empty returns 0 and changes nothing.
- R5: Offset 0x08 bit 0 reads 1 exactly when the receive FIFO holds no bytes.
- R6: Offset 0x0C reads the raw conditions: bit 0 is transmit-full and bit 1 is receive-not-empty. Writes to it have no effect.
- R7: Pending register at offset 0x10, bit 0 (transmit event): it is set at the edge where transmit-full falls and holds until a write with wdata[0]=1 to 0x10. If both happen on the same edge, the set wins.
- R8: Pending bit 1 (receive event) reads 1 whenever the receive FIFO is non-empty, even right after a write of 1 to it. It reads 0 once the FIFO has drained.
- R9: Enable register at offset 0x14: bits 1:0 are read/write (bit 0 transmit, bit 1 receive), and bits 31:2 read 0.
- R10: irq is 1 exactly when (enable bit 0 AND pending bit 0) OR (enable bit 1 AND pending bit 1). It changes in the same cycle as the register state.
- R11: A byte access (bus_byte=1) whose address bits 1:0 are non-zero returns 0 on read, is ignored on write and pops nothing. An aligned byte access acts like a word access on the low byte. Unlisted offsets read 0.
- R12: After reset: the FIFO is empty, the transmit stage is empty, pending and enable are 0, irq is 0, and offset 0x08 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte-sized access |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream accepts the transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so it is compared in the same cycle as the access. Every state change caused by an access, a received byte or a transmit handshake shows up at the ports one edge later: on tx_valid, on irq, and on the next read. The reference model advances on each rising edge from the inputs held since the previous falling edge. All outputs are compared a quarter period after the falling edge, so each result is checked in the first cycle it is due. Directed sequences then read the registers back at fixed points to cover the drop, clear and alignment corners.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_byte,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [5:0] IDX_DATA = 6'd0, IDX_TXF = 6'd1, IDX_RXE = 6'd2,
                         IDX_RAW = 6'd3, IDX_PEND = 6'd4, IDX_EN = 6'd5;

  logic [7:0]    fifo_mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] rx_count, count_nxt;
  logic          tx_full;
  logic [7:0]    tx_hold;
  logic [1:0]    ev_pend, ev_en;

  wire       misal   = bus_byte && (bus_addr[1:0] != 2'b00);
  wire [5:0] idx     = bus_addr[7:2];
  wire       wr_ok   = bus_sel && !misal && bus_wr;
  wire       rd_ok   = bus_sel && !misal && !bus_wr;
  wire       rx_empty = (rx_count == '0);
  wire       push    = rx_valid && (rx_count != CW'(DEPTH));
  wire       pop     = rd_ok && (idx == IDX_DATA) && !rx_empty;
  wire       tx_load = wr_ok && (idx == IDX_DATA) && !tx_full;
  wire       tx_take = tx_full && tx_ready;
  wire       wr_pend = wr_ok && (idx == IDX_PEND);
  wire       wr_en   = wr_ok && (idx == IDX_EN);
  wire       rx_reeval = wr_pend || wr_en || push || (pop && count_nxt == '0);

  assign count_nxt = rx_count + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) fifo_mem[wr_ptr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      rx_count <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      rx_count <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (tx_load) begin
      tx_full <= 1'b1;
      tx_hold <= bus_wdata[7:0];
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_pend <= '0;
      ev_en   <= '0;
    end else begin
      if (tx_take)                      ev_pend[0] <= 1'b1;
      else if (wr_pend && bus_wdata[0]) ev_pend[0] <= 1'b0;
      if (rx_reeval)                    ev_pend[1] <= (count_nxt != '0);
      if (wr_en)                        ev_en <= bus_wdata[1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (idx)
        IDX_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : fifo_mem[rd_ptr];
        IDX_TXF:  bus_rdata[0]   = tx_full;
        IDX_RXE:  bus_rdata[0]   = rx_empty;
        IDX_RAW:  bus_rdata[1:0] = {!rx_empty, tx_full};
        IDX_PEND: bus_rdata[1:0] = ev_pend;
        IDX_EN:   bus_rdata[1:0] = ev_en;
        default:  bus_rdata      = '0;
      endcase
    end
  end

  assign tx_valid = tx_full;
  assign tx_data  = tx_hold;
  assign irq      = |(ev_en & ev_pend);
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic [1:0] ev_pend,
  input logic [$clog2(DEPTH+1)-1:0] rx_count
);
  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R2
  tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  // R7
  tx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> ev_pend[0]);

  // R8
  rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |-> ev_pend[1]);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= ($clog2(DEPTH+1))'(DEPTH));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 8'h00 && rx_count == '0 && !rx_valid)
      |=> (rx_count == '0));
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .ev_pend(ev_pend),
  .rx_count(rx_count)
);

// File: tb/uart_regfront_test.sv
`timescale 1ns/1ps
module uart_regfront_test;
  localparam int DEPTH = 16;
  localparam time TCK = 20ns;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_byte = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, tx_ready = 0, tx_valid, irq;
  logic [7:0] rx_data = 0, tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  uart_regfront #(.DEPTH(DEPTH)) uut (.*);

  logic [7:0] m_q[$];
  bit m_full = 0, m_p0 = 0;
  logic [7:0] m_hold = 0;
  logic [1:0] m_en = 0;
  bit s_mis, s_acc, s_take, s_pop, s_push;
  int s_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_full = 0; m_p0 = 0; m_hold = 0; m_en = 0;
    end else begin
      s_mis  = bus_byte && (bus_addr[1:0] != 0);
      s_acc  = bus_sel && !s_mis;
      s_idx  = int'(bus_addr >> 2);
      s_take = m_full && tx_ready;
      s_pop  = s_acc && !bus_wr && s_idx == 0 && m_q.size() > 0;
      s_push = rx_valid && m_q.size() < DEPTH;
      if (s_pop)  void'(m_q.pop_front());
      if (s_push) m_q.push_back(rx_data);
      if (s_acc && bus_wr && s_idx == 0 && !m_full) begin
        m_full = 1; m_hold = bus_wdata[7:0];
      end else if (s_take) m_full = 0;
      if (s_take) m_p0 = 1;
      else if (s_acc && bus_wr && s_idx == 4 && bus_wdata[0]) m_p0 = 0;
      if (s_acc && bus_wr && s_idx == 5) m_en = bus_wdata[1:0];
    end
  end

  function automatic logic [31:0] exp_rd();
    bit ne = m_q.size() != 0;
    if (bus_byte && bus_addr[1:0] != 0) return 0;
    case (bus_addr >> 2)
      0: return ne ? {24'h0, m_q[0]} : 0;
      1: return {31'h0, m_full};
      2: return {31'h0, !ne};
      3: return {30'h0, ne, m_full};
      4: return {30'h0, ne, m_p0};
      5: return {30'h0, m_en};
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag();
    if (bus_byte && bus_addr[1:0] != 0) return "R11";
    case (bus_addr >> 2)
      0: return "R4";
      1: return "R2";
      2: return "R5";
      3: return "R6";
      4: return "R7/R8";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R2", {31'h0, tx_valid}, {31'h0, m_full});
      if (m_full) chk("R1", {24'h0, tx_data}, {24'h0, m_hold});
      chk("R10", {31'h0, irq},
          {31'h0, (m_en[0] & m_p0) | (m_en[1] & (m_q.size() != 0))});
      if (bus_sel && !bus_wr) chk(rd_tag(), bus_rdata, exp_rd());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, bit by = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_byte = by; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_byte = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag, bit by = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_byte = by; bus_addr = a;
    #5 chk(tag, bus_rdata, e);
    @(negedge clk);
    bus_sel = 0; bus_byte = 0;
  endtask

  task automatic rx(logic [7:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    chk("R12", {31'h0, tx_valid}, 0);
    chk("R12", {31'h0, irq}, 0);
    rd(8'h08, 1, "R12");
    rd(8'h10, 0, "R12");
    rd(8'h14, 0, "R12");

    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 3, "R9");

    wr(8'h00, 32'h0000_01A5);
    rd(8'h04, 1, "R2");
    wr(8'h00, 32'h5A);
    @(negedge clk); #5;
    chk("R1", {24'h0, tx_data}, 32'hA5);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    rd(8'h04, 0, "R2");
    rd(8'h10, 1, "R7");
    #1 chk("R10", {31'h0, irq}, 1);
    wr(8'h0C, 32'h3);
    rd(8'h0C, 0, "R6");
    wr(8'h10, 32'h1);
    rd(8'h10, 0, "R7");

    rx(8'h11); rx(8'h22); rx(8'h33);
    rd(8'h0C, 2, "R6");
    rd(8'h10, 2, "R8");
    wr(8'h10, 32'h2);
    rd(8'h10, 2, "R8");
    wr(8'h14, 32'h1);
    #1 chk("R10", {31'h0, irq}, 0);
    wr(8'h14, 32'h3);
    rd(8'h00, 32'h11, "R4");
    rd(8'h00, 32'h22, "R4");
    rd(8'h00, 32'h33, "R4");
    rd(8'h08, 1, "R5");
    rd(8'h10, 0, "R8");
    rd(8'h00, 0, "R4");
    rd(8'h08, 1, "R4");

    wr(8'h15, 32'h0, 1);
    rd(8'h14, 3, "R11");
    rx(8'h44);
    rd(8'h01, 0, "R11", 1);
    rd(8'h08, 0, "R11");
    rd(8'h00, 32'h44, "R11", 1);
    rd(8'h40, 0, "R11");

    for (int i = 0; i < DEPTH + 1; i++) rx(8'(8'h80 + i));
    rd(8'h0C, 2, "R3");
    for (int i = 0; i < DEPTH; i++) rd(8'h00, 32'(8'h80 + i), "R3");
    rd(8'h08, 1, "R3");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rx_valid = ($urandom % 3) == 0;
      rx_data  = 8'($urandom);
      tx_ready = ($urandom % 4) == 0;
      bus_sel  = ($urandom % 2) == 0;
      bus_wr   = ($urandom % 2) == 0;
      bus_byte = ($urandom % 3) == 0;
      bus_addr = 8'(($urandom % 7) * 4);
      if (bus_byte && ($urandom % 3) == 0) bus_addr = bus_addr + 8'(1 + $urandom % 3);
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_sel = 0; rx_valid = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule